// File: doc/BRIEF.md
# Page Translation Cache with Access Checks

This block turns a virtual address into a physical address for data loads, data stores and instruction fetches. A request carries the address, the access kind, the access size as a power of two and a flag that marks supervisor mode. One cycle after a request is accepted the block checks alignment, then looks up a direct-mapped array of cached page entries. On a hit it answers at once. On a miss it asks an external page walker for the entry, writes the result into the array and answers from it. Every answer is either a physical address or a trap with a cause code.

A page-table base register can be written at any time. The block stores the value with its in-page offset bits cleared, drives it out to the walker and invalidates every cached entry. The virtual address of the most recent faulting access is held for read-back.

Top module: `xlat_tlb`

## Requirements
- R1: After reset busy, rsp_valid and walk_req_valid are low, and base_q and badaddr are zero.
- R2: An address that is not a multiple of 2^req_size traps before any lookup, without a walk request, with cause 0 for a fetch, 4 for a load (req_kind 0) and 6 for a store (req_kind 1); req_kind 2 is a fetch.
- R3: A miss raises walk_req_valid with the VPN (vaddr >> 12) until walk_rsp_valid; the returned entry is cached, so a later access to the same page answers without a walk.
- R4: An entry counts as a hit only when its bit 1 (leaf-valid) is set and its stored tag equals the full VPN; a walker entry with bit 1 clear gives an access fault and a new walk on the next access to that page.
- R5: In user mode a load needs entry bit 6, a store bit 5 and a fetch bit 4; a missing bit gives access fault cause 5 (load), 7 (store) or 1 (fetch).
- R6: In supervisor mode the needed bit moves up by three: load bit 9, store bit 8, fetch bit 7.
- R7: A successful answer has rsp_paddr equal to entry bits 31:12 above virtual address bits 11:0.
- R8: Writing the base register stores the value with bits 11:0 cleared and invalidates every cached entry.
- R9: badaddr takes the virtual address of each trapped access when that trap is answered and changes at no other time.
- R10: The array slot is VPN mod 256; a second page that maps to the same slot evicts the first, while pages in other slots stay cached.
- R11: When a base write and a walker response fall in the same cycle, the invalidation wins: the answer still comes from the walker entry, but the next access to that page walks again.
- R12: A request is taken only while busy is low; requests offered while busy are ignored, and each accepted request yields exactly one single-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Offer of a translation request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_size | input | 2 | log2 of access size in bytes |
| req_super | input | 1 | Supervisor-mode access |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | Answer pulse |
| rsp_trap | output | 1 | Answer is a trap |
| rsp_cause | output | 4 | Trap cause, valid with rsp_trap |
| rsp_paddr | output | 32 | Physical address, valid without rsp_trap |
| walk_req_valid | output | 1 | Walk request to the page walker |
| walk_req_vpn | output | 20 | Page number to walk |
| walk_rsp_valid | input | 1 | Walker result pulse |
| walk_rsp_pte | input | 32 | Walker result entry |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | 32 | Base register write value |
| base_q | output | 32 | Page-aligned base register |
| badaddr | output | 32 | Last faulting virtual address |

## Verification
The base-register flush and an array refill can land on the same clock edge. The bench provokes this by having its walker model raise base_we on the very cycle it returns walk_rsp_valid. It judges the outcome by the answer to that access, which must still carry the walker's page, and by a second access to the same page, which must issue a fresh walk; the new base value must read back page-aligned.

// File: rtl/xlat_tlb_pkg.sv
`timescale 1ns/1ps
package xlat_tlb_pkg;
   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   // entry layout the walker and this block agree on
   localparam int LEAF_BIT = 1;
   localparam int PERM_LSB = 4;
   localparam int SUP_SHIFT = 3;

   typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WALK, S_FIN} xl_state_e;

   function automatic logic [3:0] trap_code(input logic [1:0] kind, input logic misal);
      case (kind)
         ACC_FETCH: trap_code = misal ? 4'd0 : 4'd1;
         ACC_STORE: trap_code = misal ? 4'd6 : 4'd7;
         default:   trap_code = misal ? 4'd4 : 4'd5;
      endcase
   endfunction
endpackage

// File: rtl/tlbx_store.sv
`timescale 1ns/1ps
module tlbx_store #(
   parameter int ENTRIES = 256,
   parameter int TAG_W   = 20,
   parameter int PTE_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PTE_W-1:0] rd_pte,
   output logic             rd_live,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PTE_W-1:0] wr_pte
);
   if (ENTRIES != (1 << IDX_W)) begin : g_bad_depth
      $error("tlbx_store: ENTRIES must be a power of two");
   end

   logic [TAG_W-1:0] tag_mem [ENTRIES];
   logic [PTE_W-1:0] pte_mem [ENTRIES];
   logic [ENTRIES-1:0] live;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_live
      always_ff @(posedge clk) begin
         if (!rst_n || flush)
            live[g] <= 1'b0;
         else if (wr_en && wr_idx == IDX_W'(g))
            live[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx] <= wr_tag;
         pte_mem[wr_idx] <= wr_pte;
      end
   end

   assign rd_tag  = tag_mem[rd_idx];
   assign rd_pte  = pte_mem[rd_idx];
   assign rd_live = live[rd_idx];
endmodule

// File: rtl/tlbx_check.sv
`timescale 1ns/1ps
module tlbx_check
   import xlat_tlb_pkg::*;
#(
   parameter int PTE_W    = 32,
   parameter bit SUP_PERM = 1'b1
) (
   input  logic [1:0]       kind,
   input  logic [1:0]       size,
   input  logic             sup,
   input  logic [2:0]       va_lo,
   input  logic [PTE_W-1:0] pte,
   output logic             misal,
   output logic             deny
);
   logic [3:0] amask;
   logic [3:0] base_sel;
   logic [3:0] sel;
   logic [PTE_W-1:0] shifted;

   assign amask = (4'd1 << size) - 4'd1;
   assign misal = |(va_lo & amask[2:0]);

   always_comb begin
      case (kind)
         ACC_STORE: base_sel = 4'd1;
         ACC_FETCH: base_sel = 4'd0;
         default:   base_sel = 4'd2;
      endcase
   end

   if (SUP_PERM) begin : g_sup_bits
      assign sel = base_sel + (sup ? 4'(SUP_SHIFT) : 4'd0);
   end else begin : g_user_bits
      assign sel = base_sel;
   end

   assign shifted = pte >> (PERM_LSB + int'(sel));
   assign deny    = ~shifted[0];
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
   import xlat_tlb_pkg::*;
#(
   parameter int VA_W     = 32,
   parameter int PTE_W    = 32,
   parameter int PGSHIFT  = 12,
   parameter int ENTRIES  = 256,
   parameter bit SUP_PERM = 1'b1,
   localparam int VPN_W   = VA_W - PGSHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic [1:0]       req_size,
   input  logic             req_super,
   output logic             busy,
   output logic             rsp_valid,
   output logic             rsp_trap,
   output logic [3:0]       rsp_cause,
   output logic [PTE_W-1:0] rsp_paddr,
   output logic             walk_req_valid,
   output logic [VPN_W-1:0] walk_req_vpn,
   input  logic             walk_rsp_valid,
   input  logic [PTE_W-1:0] walk_rsp_pte,
   input  logic             base_we,
   input  logic [PTE_W-1:0] base_wdata,
   output logic [PTE_W-1:0] base_q,
   output logic [VA_W-1:0]  badaddr
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [PTE_W-1:0] OFS_MASK = PTE_W'((64'd1 << PGSHIFT) - 64'd1);

   if (VPN_W < IDX_W || PGSHIFT < 3 || PTE_W <= PGSHIFT) begin : g_bad_geom
      $error("xlat_tlb: address geometry does not fit the array");
   end

   xl_state_e        state;
   logic [VA_W-1:0]  va_q;
   logic [1:0]       kind_q;
   logic [1:0]       size_q;
   logic             sup_q;

   logic [VPN_W-1:0] vpn;
   logic [IDX_W-1:0] idx;
   logic [VPN_W-1:0] rd_tag;
   logic [PTE_W-1:0] rd_pte;
   logic             rd_live;
   logic             hit, misal, deny, fault_acc;
   logic             fin_now, fin_trap;
   logic [3:0]       fin_code;

   assign vpn = va_q[VA_W-1:PGSHIFT];
   assign idx = vpn[IDX_W-1:0];

   tlbx_store #(.ENTRIES(ENTRIES), .TAG_W(VPN_W), .PTE_W(PTE_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (base_we),
      .rd_idx (idx),
      .rd_tag (rd_tag),
      .rd_pte (rd_pte),
      .rd_live(rd_live),
      .wr_en  (state == S_WALK && walk_rsp_valid),
      .wr_idx (idx),
      .wr_tag (vpn),
      .wr_pte (walk_rsp_pte)
   );

   tlbx_check #(.PTE_W(PTE_W), .SUP_PERM(SUP_PERM)) u_check (
      .kind (kind_q),
      .size (size_q),
      .sup  (sup_q),
      .va_lo(va_q[2:0]),
      .pte  (rd_pte),
      .misal(misal),
      .deny (deny)
   );

   assign hit       = rd_live && rd_pte[LEAF_BIT] && (rd_tag == vpn);
   assign fault_acc = deny | ~rd_pte[LEAF_BIT];

   always_comb begin
      fin_now  = 1'b0;
      fin_trap = 1'b0;
      fin_code = trap_code(kind_q, 1'b0);
      case (state)
         S_LOOK: begin
            if (misal) begin
               fin_now  = 1'b1;
               fin_trap = 1'b1;
               fin_code = trap_code(kind_q, 1'b1);
            end else if (hit) begin
               fin_now  = 1'b1;
               fin_trap = fault_acc;
            end
         end
         S_FIN: begin
            fin_now  = 1'b1;
            fin_trap = fault_acc;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         va_q      <= '0;
         kind_q    <= ACC_LOAD;
         size_q    <= '0;
         sup_q     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_trap  <= 1'b0;
         rsp_cause <= '0;
         rsp_paddr <= '0;
         base_q    <= '0;
         badaddr   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (base_we)
            base_q <= base_wdata & ~OFS_MASK;
         case (state)
            S_IDLE: if (req_valid) begin
               va_q   <= req_vaddr;
               kind_q <= req_kind;
               size_q <= req_size;
               sup_q  <= req_super;
               state  <= S_LOOK;
            end
            S_LOOK: if (!fin_now) state <= S_WALK;
            S_WALK: if (walk_rsp_valid) state <= S_FIN;
            default: ;
         endcase
         if (fin_now) begin
            state     <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_trap  <= fin_trap;
            rsp_cause <= fin_trap ? fin_code : 4'd0;
            rsp_paddr <= {rd_pte[PTE_W-1:PGSHIFT], va_q[PGSHIFT-1:0]};
            if (fin_trap)
               badaddr <= va_q;
         end
      end
   end

   assign busy           = (state != S_IDLE);
   assign walk_req_valid = (state == S_WALK);
   assign walk_req_vpn   = vpn;
endmodule

// File: rtl/xlat_tlb_chk.sv
`timescale 1ns/1ps
module xlat_tlb_chk #(
   parameter int VA_W    = 32,
   parameter int PGSHIFT = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [VA_W-1:0]    req_vaddr,
   input logic [1:0]         req_size,
   input logic               busy,
   input logic               rsp_valid,
   input logic               rsp_trap,
   input logic [PGSHIFT-1:0] rsp_paddr_lo,
   input logic               walk_req_valid,
   input logic [VA_W-1:0]    badaddr
);
   logic [VA_W-1:0] cap_va;
   logic [1:0]      cap_size;
   logic [VA_W-1:0] cap_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_va   <= '0;
         cap_size <= '0;
      end else if (req_valid && !busy) begin
         cap_va   <= req_vaddr;
         cap_size <= req_size;
      end
   end

   assign cap_mask = (VA_W'(1) << cap_size) - VA_W'(1);

   // R12: one pulse per answer
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R1: no walk without a request in progress
   a_r1_walk_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |-> busy);
   // R2: a misaligned access never reaches the walker
   a_r2_no_walk_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |-> (cap_va & cap_mask) == '0);
   // R7: page offset passes through
   a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_trap |-> rsp_paddr_lo == cap_va[PGSHIFT-1:0]);
   // R9: the held address is the faulting one
   a_r9_bad_is_fault_va: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_trap |-> badaddr == cap_va);
   // R9: it moves only with a trap answer
   a_r9_bad_only_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(badaddr) |-> rsp_valid && rsp_trap);
endmodule

bind xlat_tlb xlat_tlb_chk #(.VA_W(VA_W), .PGSHIFT(PGSHIFT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_vaddr     (req_vaddr),
   .req_size      (req_size),
   .busy          (busy),
   .rsp_valid     (rsp_valid),
   .rsp_trap      (rsp_trap),
   .rsp_paddr_lo  (rsp_paddr[PGSHIFT-1:0]),
   .walk_req_valid(walk_req_valid),
   .badaddr       (badaddr)
);

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_size = '0;
   logic        req_super = 1'b0;
   logic        busy, rsp_valid, rsp_trap, walk_req_valid;
   logic [3:0]  rsp_cause;
   logic [31:0] rsp_paddr, base_q, badaddr;
   logic [19:0] walk_req_vpn;
   logic        walk_rsp_valid = 1'b0;
   logic [31:0] walk_rsp_pte = '0;
   logic        base_we = 1'b0;
   logic [31:0] base_wdata = '0;

   xlat_tlb uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .req_size(req_size), .req_super(req_super), .busy(busy),
      .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
      .rsp_paddr(rsp_paddr), .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
      .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pte(walk_rsp_pte), .base_we(base_we),
      .base_wdata(base_wdata), .base_q(base_q), .badaddr(badaddr));

   always #10 clk = ~clk;

   typedef struct {
      logic        trap;
      logic [3:0]  cause;
      logic [31:0] pa;
      string       rq;
   } exp_t;

   exp_t        sb[$];
   int          n_vec = 0;
   int          n_bad = 0;
   int          walks = 0;
   bit          flush_on_rsp = 1'b0;
   logic [31:0] flush_val = '0;
   logic [31:0] pmap [logic [19:0]];
   bit          done = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   function automatic exp_t predict(input logic [31:0] va, input logic [1:0] kind,
                                    input logic [1:0] size, input bit sup,
                                    input logic [31:0] pte, input string rq);
      exp_t e;
      int   bitpos;
      e.rq = rq; e.trap = 1'b0; e.cause = 4'd0;
      e.pa = {pte[31:12], va[11:0]};
      if ((va & ((32'd1 << size) - 32'd1)) != 0) begin
         e.trap  = 1'b1;
         e.cause = (kind == 2'd2) ? 4'd0 : (kind == 2'd1) ? 4'd6 : 4'd4;
      end else begin
         bitpos = (kind == 2'd1) ? 5 : (kind == 2'd2) ? 4 : 6;
         if (sup) bitpos += 3;
         if (!pte[1] || !pte[bitpos]) begin
            e.trap  = 1'b1;
            e.cause = (kind == 2'd2) ? 4'd1 : (kind == 2'd1) ? 4'd7 : 4'd5;
         end
      end
      return e;
   endfunction

   // walker model: answers two cycles after seeing a request
   initial forever begin
      @(negedge clk);
      if (walk_req_valid) begin
         walks++;
         repeat (2) @(negedge clk);
         walk_rsp_pte   = pmap.exists(walk_req_vpn) ? pmap[walk_req_vpn] : 32'd0;
         walk_rsp_valid = 1'b1;
         if (flush_on_rsp) begin
            base_we    = 1'b1;
            base_wdata = flush_val;
         end
         @(negedge clk);
         walk_rsp_valid = 1'b0;
         base_we        = 1'b0;
      end
   end

   // monitor
   initial forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R12", "unexpected response", rsp_paddr, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rsp_trap == e.trap, e.rq, "trap flag", {31'd0, rsp_trap}, {31'd0, e.trap});
            if (e.trap)
               chk(rsp_cause == e.cause, e.rq, "cause", {28'd0, rsp_cause}, {28'd0, e.cause});
            else
               chk(rsp_paddr == e.pa, e.rq, "paddr", rsp_paddr, e.pa);
         end
      end
   end

   task automatic access(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] size,
                         input bit sup, input logic [31:0] pte, input int walks_exp,
                         input string rq, input bit poke = 1'b0);
      exp_t        e;
      int          w0;
      logic [31:0] bad0;
      e = predict(va, kind, size, sup, pte, rq);
      @(negedge clk);
      while (busy) @(negedge clk);
      w0 = walks; bad0 = badaddr;
      sb.push_back(e);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_size = size; req_super = sup;
      @(negedge clk);
      if (poke) begin
         req_vaddr = 32'h00012000;
         repeat (3) @(negedge clk);
      end
      req_valid = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(walks - w0 == walks_exp, rq, "walk count", walks - w0, walks_exp);
      chk(badaddr == (e.trap ? va : bad0), "R9", "badaddr", badaddr, e.trap ? va : bad0);
   endtask

   task automatic write_base(input logic [31:0] v);
      @(negedge clk);
      base_we = 1'b1; base_wdata = v;
      @(negedge clk);
      base_we = 1'b0;
      chk(base_q == {v[31:12], 12'd0}, "R8", "base_q", base_q, {v[31:12], 12'd0});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      pmap[20'h00012] = 32'h800120F2;
      pmap[20'h00013] = 32'h40013042;
      pmap[20'h00050] = 32'h500500F0;
      pmap[20'h00112] = 32'h901120F2;
      pmap[20'h00020] = 32'h200200F2;
      pmap[20'h00021] = 32'h210210F2;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !rsp_valid && !walk_req_valid, "R1", "control outs",
          {29'd0, busy, rsp_valid, walk_req_valid}, 32'd0);
      chk(base_q == 0 && badaddr == 0, "R1", "regs", base_q | badaddr, 32'd0);
      rst_n = 1'b1;

      // R3 R7 miss then hits
      access(32'h00012344, 2'd0, 2'd2, 1'b0, pmap[20'h00012], 1, "R3");
      access(32'h00012008, 2'd1, 2'd3, 1'b0, pmap[20'h00012], 0, "R3");
      access(32'h00012010, 2'd2, 2'd2, 1'b0, pmap[20'h00012], 0, "R7");
      // R6 supervisor bits
      access(32'h00012020, 2'd1, 2'd2, 1'b1, pmap[20'h00012], 0, "R6");
      access(32'h00012030, 2'd2, 2'd2, 1'b1, pmap[20'h00012], 0, "R6");
      access(32'h00012034, 2'd0, 2'd2, 1'b1, pmap[20'h00012], 0, "R6");
      // R5 user bits
      access(32'h00013100, 2'd1, 2'd0, 1'b0, pmap[20'h00013], 1, "R5");
      access(32'h00013104, 2'd2, 2'd2, 1'b0, pmap[20'h00013], 0, "R5");
      access(32'h00013108, 2'd0, 2'd1, 1'b0, pmap[20'h00013], 0, "R5");
      // R2 misaligned, unmapped and mapped pages
      access(32'h00099002, 2'd0, 2'd2, 1'b0, 32'd0, 0, "R2");
      access(32'h00099001, 2'd1, 2'd1, 1'b0, 32'd0, 0, "R2");
      access(32'h00099006, 2'd2, 2'd2, 1'b0, 32'd0, 0, "R2");
      access(32'h00012001, 2'd0, 2'd1, 1'b0, pmap[20'h00012], 0, "R2");
      // R4 leaf bit clear
      access(32'h00050000, 2'd0, 2'd0, 1'b0, pmap[20'h00050], 1, "R4");
      access(32'h00050004, 2'd0, 2'd0, 1'b0, pmap[20'h00050], 1, "R4");
      // R10 slot conflict
      access(32'h00112040, 2'd0, 2'd2, 1'b0, pmap[20'h00112], 1, "R10");
      access(32'h00012040, 2'd0, 2'd2, 1'b0, pmap[20'h00012], 1, "R10");
      access(32'h00012044, 2'd0, 2'd2, 1'b0, 32'h800120F2, 0, "R10");
      pmap[20'h00012] = 32'hA00120F2;
      access(32'h00012048, 2'd0, 2'd2, 1'b0, 32'h800120F2, 0, "R10");
      access(32'h00013108, 2'd0, 2'd1, 1'b0, pmap[20'h00013], 0, "R10");
      // R8 flush
      write_base(32'h12345FFF);
      access(32'h00013108, 2'd0, 2'd1, 1'b0, pmap[20'h00013], 1, "R8");
      access(32'h00012048, 2'd0, 2'd2, 1'b0, pmap[20'h00012], 1, "R8");
      // R11 flush and refill together
      flush_val = 32'h00ABC123; flush_on_rsp = 1'b1;
      access(32'h00020010, 2'd0, 2'd2, 1'b0, pmap[20'h00020], 1, "R11");
      flush_on_rsp = 1'b0;
      chk(base_q == 32'h00ABC000, "R11", "base_q", base_q, 32'h00ABC000);
      access(32'h00020014, 2'd0, 2'd2, 1'b0, pmap[20'h00020], 1, "R11");
      // R12 offers while busy are ignored
      access(32'h00021000, 2'd0, 2'd2, 1'b0, pmap[20'h00021], 1, "R12", 1'b1);
      repeat (5) @(negedge clk);
      chk(!busy, "R12", "idle after one answer", {31'd0, busy}, 32'd0);
      report();
   end
endmodule